// File: doc/BRIEF.md
# Wide Wrapping, Clamping and Halving Adder

This block is the execute-stage arithmetic unit for a DSP-style extension. It takes two operands of `DATA_W` bits (64 by default) and a 4-bit operation code. It produces a registered result one clock edge later. There are ten operations: wrapping add and subtract, clamping add and subtract in signed and unsigned forms, and halving add and subtract in signed and unsigned forms.

All ten operations share one `DATA_W+1`-bit adder. The extra top bit carries the sign or carry information that the clamping and halving paths need. A registered per-operation clamp strobe reports each saturation. A sticky clamp flag gathers these strobes until a clear pulse resets it.

Top module: `wide_addsub_unit`

## Requirements
- R1: Code 0 gives A+B and code 1 gives A-B, both modulo 2^DATA_W. Neither raises the clamp strobe.
- R2: Codes 2 (add) and 3 (A-B) treat both operands as two's-complement values. A result above 2^(DATA_W-1)-1 is clamped to that value, and a result below -2^(DATA_W-1) is clamped to that minimum. The clamp strobe rises only when clamping happens.
- R3: Codes 4 (add) and 5 (A-B) treat both operands as unsigned. A sum past 2^DATA_W-1 is clamped to all ones. A difference with A<B is clamped to 0. The clamp strobe rises in both cases.
- R4: Codes 6 (add) and 7 (A-B) sign-extend both operands to DATA_W+1 bits and form the sum or difference. The result is bits DATA_W..1 of that value, which is an arithmetic right shift by one. The clamp strobe never rises.
- R5: Codes 8 (add) and 9 (A-B) zero-extend both operands to DATA_W+1 bits. The result is bits DATA_W..1 of that sum or difference. The clamp strobe never rises.
- R6: Codes 10 to 15 give a zero result and a low clamp strobe, and they leave the sticky flag unchanged.
- R7: The sticky flag goes high on the same edge that presents a clamped result. It then stays high until it is cleared.
- R8: The clear input, sampled at an edge, makes the sticky flag 0 after that edge. This holds even when a clamp happens in the same cycle.
- R9: After synchronous reset the result, the strobe and the sticky flag are all 0.
- R10: Result and strobe appear on the first rising edge after the operands and code are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| opnd_a | input | DATA_W | First operand (minuend for subtraction) |
| opnd_b | input | DATA_W | Second operand (subtrahend) |
| ovf_clr | input | 1 | Clear for the sticky clamp flag |
| res_q | output | DATA_W | Registered result |
| sat_q | output | 1 | Registered clamp strobe for the previous operation |
| ovf_sticky | output | 1 | Sticky clamp flag |

## Verification
The hardest cases are the edges of the signed range. Clamping there depends on the sign of the first operand. For subtraction it also depends on the inverted sign of the second operand. A further hard case is a clamp landing in the same cycle as a clear. The bench builds the unit at 6 bits and sweeps every operand pair against every code, including the six unused ones, so every range edge is reached. A clear pulse on a fixed spacing lands on clamping operations many times during the sweep. The bench then repeats the clamp-plus-clear collision and the unused-code hold as targeted cases.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  localparam logic [3:0] OPC_ADD      = 4'd0;
  localparam logic [3:0] OPC_SUB      = 4'd1;
  localparam logic [3:0] OPC_SADD_SAT = 4'd2;
  localparam logic [3:0] OPC_SSUB_SAT = 4'd3;
  localparam logic [3:0] OPC_UADD_SAT = 4'd4;
  localparam logic [3:0] OPC_USUB_SAT = 4'd5;
  localparam logic [3:0] OPC_SADD_HLF = 4'd6;
  localparam logic [3:0] OPC_SSUB_HLF = 4'd7;
  localparam logic [3:0] OPC_UADD_HLF = 4'd8;
  localparam logic [3:0] OPC_USUB_HLF = 4'd9;

  typedef enum logic [1:0] {
    K_WRAP = 2'd0,
    K_SAT  = 2'd1,
    K_HALF = 2'd2,
    K_NONE = 2'd3
  } kind_e;

  typedef struct packed {
    logic  sub;
    logic  sgn;
    kind_e kind;
  } op_ctrl_t;

endpackage

// File: rtl/addsub_decoder.sv
module addsub_decoder
  import addsub_pkg::*;
(
  input  logic [3:0] op_i,
  output op_ctrl_t   ctrl_o
);
  always_comb begin
    ctrl_o = '{sub: 1'b0, sgn: 1'b0, kind: K_NONE};
    unique case (op_i)
      OPC_ADD:      ctrl_o = '{sub: 1'b0, sgn: 1'b0, kind: K_WRAP};
      OPC_SUB:      ctrl_o = '{sub: 1'b1, sgn: 1'b0, kind: K_WRAP};
      OPC_SADD_SAT: ctrl_o = '{sub: 1'b0, sgn: 1'b1, kind: K_SAT};
      OPC_SSUB_SAT: ctrl_o = '{sub: 1'b1, sgn: 1'b1, kind: K_SAT};
      OPC_UADD_SAT: ctrl_o = '{sub: 1'b0, sgn: 1'b0, kind: K_SAT};
      OPC_USUB_SAT: ctrl_o = '{sub: 1'b1, sgn: 1'b0, kind: K_SAT};
      OPC_SADD_HLF: ctrl_o = '{sub: 1'b0, sgn: 1'b1, kind: K_HALF};
      OPC_SSUB_HLF: ctrl_o = '{sub: 1'b1, sgn: 1'b1, kind: K_HALF};
      OPC_UADD_HLF: ctrl_o = '{sub: 1'b0, sgn: 1'b0, kind: K_HALF};
      OPC_USUB_HLF: ctrl_o = '{sub: 1'b1, sgn: 1'b0, kind: K_HALF};
      default:      ctrl_o = '{sub: 1'b0, sgn: 1'b0, kind: K_NONE};
    endcase
  end
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         sgn_i,
  output logic [W:0]   sum_o
);
  logic [W:0] a_ext, b_ext, b_op;

  always_comb begin
    a_ext = {sgn_i & a_i[W-1], a_i};
    b_ext = {sgn_i & b_i[W-1], b_i};
    b_op  = sub_i ? ~b_ext : b_ext;
    sum_o = a_ext + b_op + {{W{1'b0}}, sub_i};
  end
endmodule

// File: rtl/addsub_shaper.sv
module addsub_shaper
  import addsub_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W:0]   sum_i,
  input  logic         a_msb_i,
  input  op_ctrl_t     ctrl_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] U_MAX = {W{1'b1}};

  logic s_ovf, u_ovf;

  always_comb begin
    s_ovf = sum_i[W] ^ sum_i[W-1];
    u_ovf = sum_i[W];
    res_o = '0;
    sat_o = 1'b0;
    unique case (ctrl_i.kind)
      K_WRAP: res_o = sum_i[W-1:0];
      K_SAT: begin
        if (ctrl_i.sgn) begin
          sat_o = s_ovf;
          res_o = s_ovf ? (a_msb_i ? S_MIN : S_MAX) : sum_i[W-1:0];
        end else begin
          sat_o = u_ovf;
          res_o = u_ovf ? (ctrl_i.sub ? '0 : U_MAX) : sum_i[W-1:0];
        end
      end
      K_HALF: res_o = sum_i[W:1];
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/wide_addsub_unit.sv
module wide_addsub_unit
  import addsub_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              ovf_clr,
  output logic [DATA_W-1:0] res_q,
  output logic              sat_q,
  output logic              ovf_sticky
);
  op_ctrl_t          ctrl;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] res_n;
  logic              sat_n;

  addsub_decoder u_dec (.op_i(op_sel), .ctrl_o(ctrl));

  addsub_core #(.W(DATA_W)) u_core (
    .a_i(opnd_a), .b_i(opnd_b), .sub_i(ctrl.sub), .sgn_i(ctrl.sgn), .sum_o(sum)
  );

  addsub_shaper #(.W(DATA_W)) u_shape (
    .sum_i(sum), .a_msb_i(opnd_a[DATA_W-1]), .ctrl_i(ctrl), .res_o(res_n), .sat_o(sat_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q      <= '0;
      sat_q      <= 1'b0;
      ovf_sticky <= 1'b0;
    end else begin
      res_q      <= res_n;
      sat_q      <= sat_n;
      ovf_sticky <= ovf_clr ? 1'b0 : (ovf_sticky | sat_n);
    end
  end

  a_r1_wrap_quiet: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OPC_ADD || op_sel == OPC_SUB) |=> !sat_q);

  // R4 and R5: halving paths never clamp
  a_r4_half_quiet: assert property (@(posedge clk) disable iff (rst)
    (op_sel >= OPC_SADD_HLF && op_sel <= OPC_USUB_HLF) |=> !sat_q);

  a_r3_usub_floor: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OPC_USUB_SAT && opnd_a < opnd_b) |=> (res_q == '0 && sat_q));

  a_r6_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (op_sel > OPC_USUB_HLF && !ovf_clr) |=> (res_q == '0 && !sat_q && $stable(ovf_sticky)));

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    ovf_clr |=> !ovf_sticky);

  a_r7_sticky_holds: assert property (@(posedge clk) disable iff (rst)
    (ovf_sticky && !ovf_clr) |=> ovf_sticky);
endmodule

// File: tb/wide_addsub_unit_tb.sv
module wide_addsub_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BW   = 6;
  localparam int FULL = 1 << BW;
  localparam int HALF = 1 << (BW - 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    op_sel = '0;
  logic [BW-1:0] opnd_a = '0, opnd_b = '0;
  logic          ovf_clr = 1'b0;
  logic [BW-1:0] res_q;
  logic          sat_q, ovf_sticky;

  int checks = 0;
  int errors = 0;
  bit exp_st = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_addsub_unit #(.DATA_W(BW)) dut_i (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .ovf_clr(ovf_clr), .res_q(res_q), .sat_q(sat_q), .ovf_sticky(ovf_sticky)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    if (op <= 1) return "R1";
    if (op <= 3) return "R2";
    if (op <= 5) return "R3";
    if (op <= 7) return "R4";
    if (op <= 9) return "R5";
    return "R6";
  endfunction

  task automatic model(input int op, input int ua, input int ub, output int r, output bit ov);
    int sa, sb, t;
    sa = (ua >= HALF) ? ua - FULL : ua;
    sb = (ub >= HALF) ? ub - FULL : ub;
    ov = 1'b0;
    case (op)
      0: t = ua + ub;
      1: t = ua - ub;
      2, 3: begin
        t = (op == 2) ? sa + sb : sa - sb;
        if (t > HALF - 1) begin t = HALF - 1; ov = 1'b1; end
        if (t < -HALF) begin t = -HALF; ov = 1'b1; end
      end
      4: begin t = ua + ub; if (t > FULL - 1) begin t = FULL - 1; ov = 1'b1; end end
      5: begin t = ua - ub; if (t < 0) begin t = 0; ov = 1'b1; end end
      6: t = (sa + sb) >>> 1;
      7: t = (sa - sb) >>> 1;
      8: t = (ua + ub) >>> 1;
      9: t = (ua - ub) >>> 1;
      default: t = 0;
    endcase
    r = t & (FULL - 1);
  endtask

  // drive at a falling edge, the rising edge registers, check at the next falling edge (R10)
  task automatic run_op(input int op, input int a, input int b, input bit clr);
    int  r;
    bit  ov;
    string rq;
    op_sel = op[3:0]; opnd_a = a[BW-1:0]; opnd_b = b[BW-1:0]; ovf_clr = clr;
    model(op, a, b, r, ov);
    exp_st = clr ? 1'b0 : (exp_st | ov);
    @(negedge clk);
    rq = req_of(op);
    chk({rq, " R10 result"}, int'(res_q), r);
    chk({rq, " strobe"}, int'(sat_q), int'(ov));
    chk(clr ? "R8 sticky" : "R7 sticky", int'(ovf_sticky), int'(exp_st));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R9 reset result", int'(res_q), 0);
    chk("R9 reset strobe", int'(sat_q), 0);
    chk("R9 reset sticky", int'(ovf_sticky), 0);

    // targeted: clamp then unused codes hold the flag (R6, R7)
    run_op(2, HALF - 1, 1, 1'b0);
    run_op(12, 5, 7, 1'b0);
    run_op(15, FULL - 1, FULL - 1, 1'b0);
    // targeted: clamp and clear in the same cycle (R8)
    run_op(5, 0, 1, 1'b1);
    run_op(3, HALF, 1, 1'b0);

    for (int op = 0; op < 16; op++)
      for (int a = 0; a < FULL; a++)
        for (int b = 0; b < FULL; b++)
          run_op(op, a, b, ((a * 7 + b + op) % 11) == 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule